// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block fronts a small array of 32-bit one-time-programmable fuse words. A fuse bit can only change from 0 to 1. A simple single-cycle register bus reaches five control registers and a window of fuse words. The window starts at 0x1000, and word n sits at 0x1000 + 4*n. A write into the window burns the written ones into the word. A read returns the word's contents.

The controller only burns fuses after software has done three things: loaded the key 0x8810 into the key register, switched on both programming supplies, and set the program-enable bit. A word can be burned twice, into a primary copy and a spare copy, and a read can merge the two copies. After a burn the controller can read the word back and check it. A word can also be sealed for good against further burns. Every refused or failed access sets a sticky error bit, and software clears these bits by writing ones to them.

The fuse model has one primary copy with weak cells. The parameters `WEAK_BLK` and `WEAK_MASK` name the cells in that copy that never blow. This makes a lost bit visible, so the spare-copy recovery and the readback check can be tested.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: The registers sit at these offsets: control 0x20, error status 0x24, error clear 0x28, key 0x2C, supply 0x54. Control keeps bits 4:0, key keeps all 32 bits and supply keeps bits 2:0. Reads return the stored value with the upper bits zero. The error clear register, unmapped offsets and misaligned window addresses read as zero, and writes to them have no effect.
- R2: A write to word n (0x1000 + 4*n) while key == 0x8810 and supply bits 0, 1 and 2 are all 1 ORs the data into the word. A later read with control bit0 set returns the old value ORed with the data. A 0 never clears a burnt bit.
- R3: A window write while the key register differs from 0x8810 sets error bit0 and leaves the array unchanged. Writing 0 to the key withdraws permission.
- R4: A window write with any of supply bits 0, 1 or 2 clear sets error bit1 and leaves the array unchanged. Bit0 and bit1 can be set by the same write.
- R5: A window read with control bit0 (read supply) clear returns 0 and sets error bit4.
- R6: With control bit2 (double mode) set, a burn also ORs the data into a spare copy, and reads return primary OR spare. With bit2 clear, reads return only the primary copy. In the primary copy of word `WEAK_BLK`, the bits in `WEAK_MASK` never blow.
- R7: With control bit1 (auto-check) set, the word is compared after the burn, in the current double mode, against its old view ORed with the data. A mismatch sets error bit3, and the burn still takes effect.
- R8: A permitted window write with control bit4 (seal) set burns nothing and seals the word. A later permitted burn to a sealed word sets error bit2 and changes nothing. Sealed words still read normally.
- R9: A window access to an index at or beyond `NUM_BLK` sets error bit5, returns 0 on a read and changes nothing.
- R10: Writing to the error clear register clears every error bit whose matching data bit (13:0) is 1 and leaves the other bits as they were. Error bits 13:6 always read 0.
- R11: After reset all registers read 0 and every fuse word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read strobe |

## Verification
Burning a word and checking it happen in the same cycle, so one window write both updates the array and decides the auto-check flag from the post-burn view. The bench provokes this on the weak word. It burns the word with auto-check on and double mode off, so the weak cell is lost. It then burns again with double mode on, so the spare copy restores the bit. In each case it judges the outcome by reading both the error status and the word in both read modes. Sealing and burning share the same permission path, and the bench tests this by sealing with and without the key.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int ERR_W  = 14;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 16'h0020;
  localparam logic [ADDR_W-1:0] OFF_ERR  = 16'h0024;
  localparam logic [ADDR_W-1:0] OFF_CLR  = 16'h0028;
  localparam logic [ADDR_W-1:0] OFF_KEY  = 16'h002C;
  localparam logic [ADDR_W-1:0] OFF_SUP  = 16'h0054;
  localparam logic [3:0]        WIN_TAG  = 4'h1;

  localparam logic [DATA_W-1:0] KEY_VAL  = 32'h0000_8810;

  localparam int E_NOKEY  = 0;
  localparam int E_NOSUP  = 1;
  localparam int E_SEALED = 2;
  localparam int E_CHECK  = 3;
  localparam int E_NORDP  = 4;
  localparam int E_RANGE  = 5;
  localparam logic [ERR_W-1:0] ERR_IMPL = 14'h003F;

  typedef struct packed {
    logic seal;
    logic margin;
    logic dbl;
    logic chk;
    logic rd_sup;
  } ctrl_t;

  typedef struct packed {
    logic prog_en;
    logic sup_b;
    logic sup_a;
  } sup_t;
endpackage

// File: rtl/otp_ctrl_regs.sv
module otp_ctrl_regs
  import otp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              key_we_i,
  input  logic              sup_we_i,
  input  logic              clr_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ERR_W-1:0]  err_set_i,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] key_o,
  output sup_t              sup_o,
  output logic [ERR_W-1:0]  err_o
);
  ctrl_t             ctrl_q;
  sup_t              sup_q;
  logic [DATA_W-1:0] key_q;
  logic [ERR_W-1:0]  err_q, err_d, clr_mask;

  assign clr_mask = clr_we_i ? wdata_i[ERR_W-1:0] : '0;
  assign err_d    = (err_q & ~clr_mask) | (err_set_i & ERR_IMPL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      sup_q  <= '0;
      key_q  <= '0;
      err_q  <= '0;
    end else begin
      if (ctrl_we_i) ctrl_q <= ctrl_t'(wdata_i[$bits(ctrl_t)-1:0]);
      if (sup_we_i)  sup_q  <= sup_t'(wdata_i[$bits(sup_t)-1:0]);
      if (key_we_i)  key_q  <= wdata_i;
      err_q <= err_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign sup_o  = sup_q;
  assign key_o  = key_q;
  assign err_o  = err_q;
endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array
  import otp_pkg::*;
#(
  parameter int              NUM_BLK   = 96,
  parameter int              IDX_W     = 7,
  parameter int              WEAK_BLK  = 5,
  parameter logic [DATA_W-1:0] WEAK_MASK = 32'h0000_0100
)(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              burn_i,
  input  logic              dbl_i,
  input  logic              seal_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] prim_o,
  output logic [DATA_W-1:0] spare_o,
  output logic [DATA_W-1:0] prim_nx_o,
  output logic [DATA_W-1:0] spare_nx_o,
  output logic              sealed_o
);
  logic [DATA_W-1:0] prim_q  [NUM_BLK];
  logic [DATA_W-1:0] spare_q [NUM_BLK];
  logic [NUM_BLK-1:0] seal_q;
  logic              in_rng;
  logic [DATA_W-1:0] keep;

  assign in_rng = 32'(idx_i) < 32'(NUM_BLK);
  assign keep   = (32'(idx_i) == 32'(WEAK_BLK)) ? ~WEAK_MASK : '1;

  assign prim_o     = in_rng ? prim_q[idx_i]  : '0;
  assign spare_o    = in_rng ? spare_q[idx_i] : '0;
  assign sealed_o   = in_rng ? seal_q[idx_i]  : 1'b0;
  assign prim_nx_o  = prim_o | (wdata_i & keep);
  assign spare_nx_o = dbl_i ? (spare_o | wdata_i) : spare_o;

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    logic sel;
    assign sel = idx_i == IDX_W'(b);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prim_q[b]  <= '0;
        spare_q[b] <= '0;
        seal_q[b]  <= 1'b0;
      end else begin
        if (sel && burn_i) begin
          prim_q[b]  <= prim_nx_o;
          spare_q[b] <= spare_nx_o;
        end
        if (sel && seal_i) seal_q[b] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_pkg::*;
#(
  parameter int              NUM_BLK   = 96,
  parameter int              WEAK_BLK  = 5,
  parameter logic [31:0]     WEAK_MASK = 32'h0000_0100
)(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [15:0] addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o
);
  localparam int IDX_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;
  localparam int FIELD_W = 10;

  ctrl_t             ctrl_q;
  sup_t              sup_q;
  logic [DATA_W-1:0] key_q;
  logic [ERR_W-1:0]  err_q, err_set;

  logic               is_win, in_rng, win_wr, win_rd;
  logic [FIELD_W-1:0] raw_idx;
  logic               key_ok, sup_ok, allow, do_seal, do_burn, mismatch;
  logic [DATA_W-1:0]  prim, spare, prim_nx, spare_nx, view_old, view_new;
  logic               sealed_sel;
  logic [DATA_W-1:0]  rdata_d, rdata_q;

  // window decode: aligned addresses only
  assign is_win  = (addr_i[15:12] == WIN_TAG) && (addr_i[1:0] == 2'b00);
  assign raw_idx = addr_i[11:2];
  assign in_rng  = 32'(raw_idx) < 32'(NUM_BLK);
  assign win_wr  = req_i && we_i && is_win;
  assign win_rd  = req_i && !we_i && is_win;

  assign key_ok  = key_q == KEY_VAL;
  assign sup_ok  = &sup_q;
  assign allow   = win_wr && in_rng && key_ok && sup_ok;
  assign do_seal = allow && ctrl_q.seal;
  assign do_burn = allow && !ctrl_q.seal && !sealed_sel;

  assign view_old = ctrl_q.dbl ? (prim | spare) : prim;
  assign view_new = ctrl_q.dbl ? (prim_nx | spare_nx) : prim_nx;
  assign mismatch = view_new != (view_old | wdata_i);

  always_comb begin
    err_set = '0;
    if (req_i && is_win && !in_rng) err_set[E_RANGE] = 1'b1;
    if (win_wr && in_rng) begin
      err_set[E_NOKEY]  = !key_ok;
      err_set[E_NOSUP]  = !sup_ok;
      err_set[E_SEALED] = allow && !ctrl_q.seal && sealed_sel;
      err_set[E_CHECK]  = do_burn && ctrl_q.chk && mismatch;
    end
    if (win_rd && in_rng && !ctrl_q.rd_sup) err_set[E_NORDP] = 1'b1;
  end

  otp_ctrl_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_we_i (req_i && we_i && addr_i == OFF_CTRL),
    .key_we_i  (req_i && we_i && addr_i == OFF_KEY),
    .sup_we_i  (req_i && we_i && addr_i == OFF_SUP),
    .clr_we_i  (req_i && we_i && addr_i == OFF_CLR),
    .wdata_i   (wdata_i),
    .err_set_i (err_set),
    .ctrl_o    (ctrl_q),
    .key_o     (key_q),
    .sup_o     (sup_q),
    .err_o     (err_q)
  );

  otp_fuse_array #(
    .NUM_BLK   (NUM_BLK),
    .IDX_W     (IDX_W),
    .WEAK_BLK  (WEAK_BLK),
    .WEAK_MASK (WEAK_MASK)
  ) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_i      (in_rng ? IDX_W'(raw_idx) : '0),
    .burn_i     (do_burn),
    .dbl_i      (ctrl_q.dbl),
    .seal_i     (do_seal),
    .wdata_i    (wdata_i),
    .prim_o     (prim),
    .spare_o    (spare),
    .prim_nx_o  (prim_nx),
    .spare_nx_o (spare_nx),
    .sealed_o   (sealed_sel)
  );

  always_comb begin
    rdata_d = '0;
    if (req_i && !we_i) begin
      if (is_win) begin
        if (in_rng && ctrl_q.rd_sup) rdata_d = view_old;
      end else begin
        case (addr_i)
          OFF_CTRL: rdata_d = DATA_W'(ctrl_q);
          OFF_ERR:  rdata_d = DATA_W'(err_q);
          OFF_KEY:  rdata_d = key_q;
          OFF_SUP:  rdata_d = DATA_W'(sup_q);
          default:  rdata_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rdata_q <= '0;
    else if (req_i && !we_i)    rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
module otp_fuse_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [15:0] addr_i,
  input logic [13:0] clr_data_i,
  input logic [31:0] rdata_o,
  input logic [4:0]  ctrl_i,
  input logic [31:0] key_i,
  input logic [2:0]  sup_i,
  input logic [13:0] err_i,
  input logic        in_rng_i,
  input logic        sealed_i
);
  logic win;
  assign win = (addr_i[15:12] == 4'h1) && (addr_i[1:0] == 2'b00);

  a_r3_no_key_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && win && in_rng_i && key_i != 32'h8810 |=> err_i[0]);

  a_r4_no_supply_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && win && in_rng_i && sup_i != 3'b111 |=> err_i[1]);

  a_r5_unpowered_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && win && in_rng_i && !ctrl_i[0] |=> rdata_o == 32'h0 && err_i[4]);

  a_r8_sealed_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && win && in_rng_i && key_i == 32'h8810 && sup_i == 3'b111
      && !ctrl_i[4] && sealed_i |=> err_i[2]);

  a_r9_range_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && win && !in_rng_i |=> err_i[5]);

  a_r10_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && addr_i == 16'h0028 |=> (err_i & $past(clr_data_i)) == 14'h0);
endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .clr_data_i (wdata_i[13:0]),
  .rdata_o    (rdata_o),
  .ctrl_i     (ctrl_q),
  .key_i      (key_q),
  .sup_i      (sup_q),
  .err_i      (err_q),
  .in_rng_i   (in_rng),
  .sealed_i   (sealed_sel)
);

// File: tb/otp_fuse_ctrl_tb_top.sv
`timescale 1ns/1ps
module otp_fuse_ctrl_tb_top;
  localparam int          NB    = 8;
  localparam int          WBLK  = 5;
  localparam logic [31:0] WMASK = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] mp [NB];
  logic [31:0] ms [NB];
  bit          mseal [NB];
  logic [4:0]  b_ctrl = '0;
  logic [31:0] b_key = '0;
  logic [2:0]  b_sup = '0;

  always #2 clk = ~clk;

  otp_fuse_ctrl #(.NUM_BLK(NB), .WEAK_BLK(WBLK), .WEAK_MASK(WMASK)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic set_ctrl(input logic [4:0] v); b_ctrl = v; wr(16'h0020, 32'(v)); endtask
  task automatic set_key(input logic [31:0] v); b_key = v; wr(16'h002C, v); endtask
  task automatic set_sup(input logic [2:0] v); b_sup = v; wr(16'h0054, 32'(v)); endtask

  task automatic check_err(input string tag, input logic [31:0] exp);
    logic [31:0] e;
    rd(16'h0024, e);
    check(tag, e, exp);
    wr(16'h0028, 32'h3FFF);
  endtask

  function automatic logic [31:0] view(input int i);
    return b_ctrl[2] ? (mp[i] | ms[i]) : mp[i];
  endfunction

  task automatic blk_wr(input string tag, input int i, input logic [31:0] d);
    logic [31:0] e = '0, old, nw;
    if (i >= NB) e[5] = 1;
    else begin
      if (b_key != 32'h8810) e[0] = 1;
      if (b_sup != 3'b111) e[1] = 1;
      if (e == 0) begin
        if (b_ctrl[4]) mseal[i] = 1;
        else if (mseal[i]) e[2] = 1;
        else begin
          old = view(i);
          mp[i] = mp[i] | (d & ((i == WBLK) ? ~WMASK : 32'hFFFF_FFFF));
          if (b_ctrl[2]) ms[i] = ms[i] | d;
          nw = view(i);
          if (b_ctrl[1] && nw != (old | d)) e[3] = 1;
        end
      end
    end
    wr(16'h1000 + 16'(i * 4), d);
    check_err({tag, " err"}, e);
  endtask

  task automatic blk_rd(input string tag, input int i);
    logic [31:0] v, exp, e = '0;
    if (i >= NB) begin exp = 0; e[5] = 1; end
    else if (!b_ctrl[0]) begin exp = 0; e[4] = 1; end
    else exp = view(i);
    rd(16'h1000 + 16'(i * 4), v);
    check({tag, " data"}, v, exp);
    check_err({tag, " err"}, e);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired got=1 exp=0");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < NB; i++) begin mp[i] = 0; ms[i] = 0; mseal[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11 reset state
    rd(16'h0020, v); check("R11 ctrl", v, 0);
    rd(16'h002C, v); check("R11 key", v, 0);
    rd(16'h0054, v); check("R11 sup", v, 0);
    rd(16'h0024, v); check("R11 err", v, 0);
    set_ctrl(5'h01);
    for (int i = 0; i < NB; i++) blk_rd("R11 blank", i);

    // R1 register map and widths
    wr(16'h0020, 32'hFFFF_FFFF); rd(16'h0020, v); check("R1 ctrl width", v, 32'h1F);
    wr(16'h0054, 32'hFFFF_FFFF); rd(16'h0054, v); check("R1 sup width", v, 32'h7);
    wr(16'h002C, 32'hDEAD_BEEF); rd(16'h002C, v); check("R1 key", v, 32'hDEAD_BEEF);
    rd(16'h0030, v); check("R1 unmapped", v, 0);
    rd(16'h0028, v); check("R1 clr reads 0", v, 0);
    rd(16'h1002, v); check("R1 misaligned", v, 0);
    set_ctrl(5'h01); set_sup(3'b000); set_key(32'h0);
    wr(16'h1001, 32'hFFFF_FFFF);
    check_err("R1 misaligned write err", 0);
    blk_rd("R1 misaligned write no burn", 0);

    // R2 R3 R4 sweep over key presence and supply combinations
    for (int k = 0; k < 2; k++) begin
      for (int p = 0; p < 8; p++) begin
        set_key(k ? 32'h8810 : 32'h0);
        set_sup(3'(p));
        blk_wr("R2/R3/R4 sweep", p, 32'h1 << (p * 4 + k));
        blk_rd("R2 sweep readback", p);
      end
    end
    set_key(32'h8810); set_sup(3'b111);
    blk_wr("R2 zero keeps bits", 7, 32'h0);
    blk_wr("R2 accumulate", 7, 32'hA000_0000);
    for (int i = 0; i < NB; i++) blk_rd("R2 final", i);
    set_key(32'h0);
    blk_wr("R3 key withdrawn", 6, 32'hFFFF_FFFF);
    blk_rd("R3 unchanged", 6);

    // R5 read without read supply
    set_ctrl(5'h00);
    blk_rd("R5 unpowered", 7);

    // R6 R7 weak cell, double mode and auto-check
    set_key(32'h8810);
    set_ctrl(5'b00011);
    blk_wr("R7 mismatch on weak cell", WBLK, 32'h0000_0101);
    blk_rd("R7 primary after mismatch", WBLK);
    set_ctrl(5'b00111);
    blk_wr("R6 double restores", WBLK, 32'h0000_0100);
    blk_rd("R6 merged view", WBLK);
    set_ctrl(5'b00011);
    blk_rd("R6 primary only view", WBLK);
    set_ctrl(5'b00111);
    blk_wr("R6 double normal word", 4, 32'h00F0_0000);
    set_ctrl(5'b00001);
    blk_rd("R6 single view", 4);

    // R8 sealing
    set_ctrl(5'b10001);
    set_key(32'h0);
    blk_wr("R8 seal needs key", 2, 32'h0);
    set_key(32'h8810);
    set_ctrl(5'b00001);
    blk_wr("R8 unsealed still burns", 2, 32'h0000_0002);
    set_ctrl(5'b10001);
    blk_wr("R8 seal no burn", 3, 32'hFFFF_0000);
    blk_rd("R8 seal no change", 3);
    set_ctrl(5'b00011);
    blk_wr("R8 sealed reject", 3, 32'h0F00_0000);
    blk_rd("R8 sealed readable", 3);

    // R9 out of range
    blk_wr("R9 write idx NB", NB, 32'hFFFF_FFFF);
    blk_wr("R9 write top idx", 1023, 32'h1);
    blk_rd("R9 read idx NB", NB);
    for (int i = 0; i < NB; i++) blk_rd("R9 array intact", i);

    // R10 selective clear
    set_key(32'h0); set_sup(3'b000);
    wr(16'h1000, 32'h1);
    rd(16'h0024, v); check("R10 both set", v, 32'h3);
    wr(16'h0028, 32'h1);
    rd(16'h0024, v); check("R10 partial clear", v, 32'h2);
    wr(16'h0028, 32'hFFFF_C000);
    rd(16'h0024, v); check("R10 upper bits ignored", v, 32'h2);
    wr(16'h0028, 32'h3FFF);
    rd(16'h0024, v); check("R10 full clear", v, 32'h0);

    done = 1;
    finish_run();
  end
endmodule